// File: doc/BRIEF.md
# Serial Peripheral Host Controller

This block is a byte-oriented SPI host driven through four 8-bit registers. Software configures the serial clock rate, idle level, sampling edge and bit count. It selects a write or read cycle, loads the data register, and then writes a per-channel start bit to run one transfer of 1 to 8 bits on one of two chip-select channels. The serial clock comes from the core clock through a small programmable divider. Data leaves and enters most significant bit first within the programmed width.

The chip select of a channel goes low on the first accepted start and stays low across any number of later transfers on that channel. It is released only when software first requests an end and then confirms it with a clear command. A write cycle drives the data register onto the output line and ignores the input line. A read cycle holds the output line low and gathers the input bits into the data register. In blocking mode, the data register holds its old value until the last bit. Otherwise it takes each bit as it is sampled.

Top module: `spi_host_ctrl`

## Requirements
- R1: With divider field N (CFG bits [2:0]), a serial clock edge occurs every N+1 core cycles. The first edge comes N+1 cycles after the start write is taken. For a W-bit transfer, busy (status bit 0) is high for exactly 2·W·(N+1) cycles.
- R2: The serial clock idles at the polarity bit (CFG bit 3) when no transfer runs, and returns to that level after every transfer. Reset value is low.
- R3: With the phase bit (CFG bit 4) at 0, bits are sampled on edges 1, 3, 5… and the next bit is presented after each sample. With the phase bit at 1, bits are presented on edges 1, 3, 5… and sampled on edges 2, 4, 6….
- R4: The width field (CFG bits [7:5]) selects 8 bits for code 0 and 1 to 7 bits for codes 1 to 7. The bits used are the low W bits of the data register.
- R5: Command register (address 3) bit 0 starts channel 0 and bit 1 starts channel 1. The started channel drives its active-low chip select cs_no[c]. A write that sets both start bits is ignored. A start for one channel while the other channel's chip select is held is ignored.
- R6: MODE bit 2 enables channel 0 and bit 3 enables channel 1. A disabled channel's chip select stays high, the serial clock sits at idle level and the output line is low. Starts on a disabled channel are ignored. Re-enabling a channel with a held chip select drives it low again.
- R7: A write cycle (MODE bit 0 = 0) shifts the data register (address 2) out MSB-first within W bits. The input line is ignored, and the data register is unchanged afterwards.
- R8: A read cycle (MODE bit 0 = 1) keeps the output line low. Afterwards the data register holds the W received bits right-aligned, with the upper bits zero.
- R9: Ending takes two commands. Writing command bit 4 sets the end-pending flag (status bit 1), but only while a chip select is held. A later write of command bit 5 releases the chip select and clears the flag, but only while the flag is already set and no transfer runs. Starts are ignored while the flag is set.
- R10: With blocking mode (MODE bit 1) set, a read cycle leaves the data register unchanged until the last bit. With it clear, the register shifts in each bit at its LSB as it is sampled.
- R11: While busy, writes to CFG, MODE, DATA and start bits are ignored. After reset, all registers and status read zero. Status bits 2 and 3 show chip selects held on channels 0 and 1.
- R12: The chip select goes low in the cycle the start is taken, at least N+1 cycles before the first clock edge. It stays low between consecutive transfers until the end command completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 CFG, 1 MODE, 2 DATA, 3 command/status |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational on addr_i) |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 2 | Active-low chip selects, one per channel |

## Verification
A register write presented before a rising edge takes effect on that edge. For a start taken at edge T, serial edge k falls on core edge T + k·(N+1), and busy and the read result change on edge T + 2·W·(N+1). The bench drives the start and then counts exactly N+1 core edges per serial edge. It inspects clock level, output bit and, in read cycles, mid-transfer register contents on the falling core edge just before each serial edge, and it presents each input bit at that same point. The busy window in the busy-time scenario is measured with a free-running cycle counter, compared against 2·W·(N+1).

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned DIV_W  = 3;
  localparam int unsigned WC_W   = $clog2(DATA_W);
  localparam int unsigned NB_W   = $clog2(DATA_W + 1);
  localparam int unsigned NCS    = 2;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;
  localparam logic [ADDR_W-1:0] A_CMD  = 2'd3;

  localparam int unsigned CMD_START0  = 0;
  localparam int unsigned CMD_END_REQ = 4;
  localparam int unsigned CMD_END_CLR = 5;

  typedef struct packed {
    logic [WC_W-1:0]  wcode;
    logic             cpha;
    logic             cpol;
    logic [DIV_W-1:0] div;
  } cfg_t;

  typedef struct packed {
    logic [NCS-1:0] en;
    logic           blocking;
    logic           rd;
  } mode_t;
endpackage

// File: rtl/spi_host_clkgen.sv
module spi_host_clkgen
  import spi_host_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
  import spi_host_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [NB_W-1:0]   nbits_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              sample_o,
  output logic              sample_bit_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  logic              busy_q, sclk_q;
  logic [NB_W:0]     edge_q, last_idx;
  logic [DATA_W-1:0] tx_q, rx_q;
  logic              step, is_sample, is_shift, is_last;

  assign last_idx  = {nbits_i, 1'b0} - 1'b1;
  assign step      = busy_q && tick_i;
  assign is_sample = (edge_q[0] == cpha_i);
  // with late sampling the first edge only presents the already loaded MSB
  assign is_shift  = !is_sample && !(cpha_i && edge_q == '0);
  assign is_last   = (edge_q == last_idx);

  assign sample_o     = step && is_sample;
  assign sample_bit_o = miso_i;
  assign done_o       = step && is_last;
  assign rx_o         = sample_o ? {rx_q[DATA_W-2:0], miso_i} : rx_q;
  assign busy_o       = busy_q;
  assign sclk_o       = sclk_q;
  assign mosi_o       = tx_q[DATA_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      edge_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      sclk_q <= cpol_i;
      edge_q <= '0;
      tx_q   <= tx_i << (NB_W'(DATA_W) - nbits_i);
      rx_q   <= '0;
    end else if (step) begin
      sclk_q <= ~sclk_q;
      if (is_sample) rx_q <= rx_o;
      if (is_shift)  tx_q <= {tx_q[DATA_W-2:0], 1'b0};
      if (is_last)   busy_q <= 1'b0;
      else           edge_q <= edge_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              sample_i,
  input  logic              sample_bit_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_i,
  output cfg_t              cfg_o,
  output mode_t             mode_o,
  output logic [DATA_W-1:0] data_o,
  output logic [NCS-1:0]    cs_open_o,
  output logic              end_pend_o,
  output logic              start_o
);
  cfg_t              cfg_q;
  mode_t             mode_q;
  logic [DATA_W-1:0] data_q;
  logic [NCS-1:0]    cs_open_q, req;
  logic              end_pend_q, wr_cmd, cfg_wr;

  assign wr_cmd = wr_en_i && (addr_i == A_CMD);
  assign cfg_wr = wr_en_i && !busy_i;
  assign req    = wdata_i[CMD_START0 +: NCS];

  always_comb begin
    start_o = 1'b0;
    if (wr_cmd && !busy_i && !end_pend_q && $onehot(req) &&
        ((req & mode_q.en) == req) &&
        (cs_open_q == '0 || cs_open_q == req))
      start_o = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      mode_q     <= '0;
      data_q     <= '0;
      cs_open_q  <= '0;
      end_pend_q <= 1'b0;
    end else begin
      if (cfg_wr) begin
        unique case (addr_i)
          A_CFG:   cfg_q  <= cfg_t'(wdata_i);
          A_MODE:  mode_q <= mode_t'(wdata_i[$bits(mode_t)-1:0]);
          A_DATA:  data_q <= wdata_i;
          default: ;
        endcase
      end
      if (busy_i && mode_q.rd) begin
        if (done_i)
          data_q <= rx_i;
        else if (sample_i && !mode_q.blocking)
          data_q <= {data_q[DATA_W-2:0], sample_bit_i};
      end
      if (start_o) cs_open_q <= req;
      if (wr_cmd && wdata_i[CMD_END_REQ] && cs_open_q != '0)
        end_pend_q <= 1'b1;
      if (wr_cmd && wdata_i[CMD_END_CLR] && end_pend_q && !busy_i) begin
        end_pend_q <= 1'b0;
        cs_open_q  <= '0;
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CFG:   rdata_o = cfg_q;
      A_MODE:  rdata_o = DATA_W'(mode_q);
      A_DATA:  rdata_o = data_q;
      default: rdata_o = DATA_W'({cs_open_q, end_pend_q, busy_i});
    endcase
  end

  assign cfg_o      = cfg_q;
  assign mode_o     = mode_q;
  assign data_o     = data_q;
  assign cs_open_o  = cs_open_q;
  assign end_pend_o = end_pend_q;
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NCS-1:0]    cs_no
);
  cfg_t              cfg;
  mode_t             mode;
  logic [DATA_W-1:0] data, rx;
  logic [NCS-1:0]    cs_open;
  logic [NB_W-1:0]   nbits;
  logic              end_pend, start, tick, eng_busy, eng_sclk, eng_mosi;
  logic              smp, smp_bit, done, act_en;

  assign nbits = (cfg.wcode == '0) ? NB_W'(DATA_W) : NB_W'(cfg.wcode);

  spi_host_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .rdata_o      (rdata_o),
    .busy_i       (eng_busy),
    .sample_i     (smp),
    .sample_bit_i (smp_bit),
    .done_i       (done),
    .rx_i         (rx),
    .cfg_o        (cfg),
    .mode_o       (mode),
    .data_o       (data),
    .cs_open_o    (cs_open),
    .end_pend_o   (end_pend),
    .start_o      (start)
  );

  spi_host_clkgen u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (eng_busy),
    .div_i  (cfg.div),
    .tick_o (tick)
  );

  spi_host_engine u_engine (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .tick_i       (tick),
    .cpol_i       (cfg.cpol),
    .cpha_i       (cfg.cpha),
    .nbits_i      (nbits),
    .tx_i         (data),
    .miso_i       (miso_i),
    .busy_o       (eng_busy),
    .sclk_o       (eng_sclk),
    .mosi_o       (eng_mosi),
    .sample_o     (smp),
    .sample_bit_o (smp_bit),
    .done_o       (done),
    .rx_o         (rx)
  );

  assign act_en = |(cs_open & mode.en);
  assign sclk_o = (eng_busy && act_en) ? eng_sclk : cfg.cpol;
  assign mosi_o = eng_busy && act_en && !mode.rd && eng_mosi;

  for (genvar c = 0; c < NCS; c++) begin : g_cs
    assign cs_no[c] = !(cs_open[c] && mode.en[c]);
  end
endmodule

// File: rtl/spi_host_ctrl_chk.sv
module spi_host_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic       eng_sclk_i,
  input logic       cpol_i,
  input logic [7:0] cfg_i,
  input logic [1:0] cs_n_i,
  input logic [1:0] cs_open_i,
  input logic       end_pend_i
);
  p_cs_exclusive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_i));

  p_sclk_returns_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> eng_sclk_i == cpol_i);

  p_cfg_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(cfg_i));

  p_release_after_request_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(cs_open_i) & ~cs_open_i) != 2'b00) |-> $past(end_pend_i));

  p_cs_held_while_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> cs_n_i != 2'b11);
endmodule

bind spi_host_ctrl spi_host_ctrl_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_i     (eng_busy),
  .eng_sclk_i (eng_sclk),
  .cpol_i     (cfg.cpol),
  .cfg_i      (cfg),
  .cs_n_i     (cs_no),
  .cs_open_i  (cs_open),
  .end_pend_i (end_pend)
);

// File: tb/test_spi_host_ctrl.sv
module test_spi_host_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       sclk, mosi;
  logic       miso = 1'b0;
  logic [1:0] cs_n;
  int         n_chk = 0;
  int         n_bad = 0;
  int         cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_host_ctrl i_spi_host_ctrl (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .sclk_o  (sclk),
    .mosi_o  (mosi),
    .miso_i  (miso),
    .cs_no   (cs_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic end_txn(input int ch);
    logic [7:0] r;
    wr(2'd3, 8'h10);
    rd(2'd3, r);
    chk("R9 end pending flag", r, 32'h02 | (32'h04 << ch));
    chk("R9 cs held after request", cs_n, ~(32'h1 << ch) & 32'h3);
    wr(2'd3, 8'h20);
    chk("R9 cs released", cs_n, 32'h3);
    rd(2'd3, r);
    chk("R9 status cleared", r, 32'h0);
  endtask

  task automatic t_reset();
    logic [7:0] r;
    chk("R6 reset cs", cs_n, 32'h3);
    chk("R2 reset sclk", sclk, 32'h0);
    chk("R6 reset mosi", mosi, 32'h0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r);
      chk("R11 reset register", r, 32'h0);
    end
  endtask

  task automatic t_write(input int ch, input int dv, input bit cpol, input bit cpha,
                         input int wc, input logic [7:0] d);
    int w, h;
    logic [7:0] r;
    w = (wc == 0) ? 8 : wc;
    h = dv + 1;
    wr(2'd0, {3'(wc), cpha, cpol, 3'(dv)});
    wr(2'd1, 8'h0C);
    wr(2'd2, d);
    @(negedge clk);
    chk("R2 idle level", sclk, 32'(cpol));
    wr(2'd3, 8'(1 << ch));
    chk("R12 cs asserted at start", cs_n, ~(32'h1 << ch) & 32'h3);
    for (int k = 1; k <= 2 * w; k++) begin
      repeat (h - 1) @(posedge clk);
      @(negedge clk);
      miso = 1'($urandom);
      chk("R1 R3 clock level before edge", sclk, 32'(cpol ^ ((k - 1) & 1)));
      if (((k - 1) & 1) == int'(cpha))
        chk("R7 R4 output bit", mosi, 32'(d[w - 1 - ((k - 1) >> 1)]));
      if (k == 2 * w) begin
        rd(2'd3, r);
        chk("R1 busy before last edge", r[0], 32'h1);
      end
      @(posedge clk);
    end
    @(negedge clk);
    rd(2'd3, r);
    chk("R1 busy clear after last edge", r[0], 32'h0);
    chk("R2 clock back to idle", sclk, 32'(cpol));
    chk("R12 cs held after transfer", cs_n, ~(32'h1 << ch) & 32'h3);
    rd(2'd2, r);
    chk("R7 data unchanged by write cycle", r, 32'(d));
  endtask

  task automatic t_read(input int ch, input int dv, input bit cpol, input bit cpha,
                        input int wc, input logic [7:0] d0, input logic [7:0] p,
                        input bit blk);
    int w, h, first_s;
    logic [7:0] r, mid, mask;
    w = (wc == 0) ? 8 : wc;
    h = dv + 1;
    first_s = cpha ? 2 : 1;
    mask = 8'((1 << w) - 1);
    mid = blk ? d0 : {d0[6:0], p[w - 1]};
    wr(2'd0, {3'(wc), cpha, cpol, 3'(dv)});
    wr(2'd1, blk ? 8'h0F : 8'h0D);
    wr(2'd2, d0);
    wr(2'd3, 8'(1 << ch));
    for (int k = 1; k <= 2 * w; k++) begin
      repeat (h - 1) @(posedge clk);
      @(negedge clk);
      chk("R8 output low in read cycle", mosi, 32'h0);
      if (k - 1 == first_s) begin
        rd(2'd2, r);
        chk(blk ? "R10 blocking holds data" : "R10 live data shift", r, 32'(mid));
      end
      if (((k - 1) & 1) == int'(cpha)) miso = p[w - 1 - ((k - 1) >> 1)];
      else                             miso = 1'($urandom);
      @(posedge clk);
    end
    @(negedge clk);
    rd(2'd2, r);
    chk("R8 R4 received data", r, 32'(p & mask));
    chk("R12 cs held after read", cs_n, ~(32'h1 << ch) & 32'h3);
  endtask

  task automatic t_busy_ignore();
    int t0, t1;
    logic [7:0] r;
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h0C);
    wr(2'd2, 8'h77);
    wr(2'd3, 8'h01);
    t0 = cyc;
    wr(2'd0, 8'hFF);
    wr(2'd2, 8'h11);
    wr(2'd1, 8'h00);
    wr(2'd3, 8'h01);
    t1 = -1;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      rd(2'd3, r);
      if (!r[0]) begin t1 = cyc; break; end
    end
    chk("R1 R11 busy duration", t1 - t0, 32'd64);
    rd(2'd0, r); chk("R11 cfg write ignored while busy", r, 32'h03);
    rd(2'd1, r); chk("R11 mode write ignored while busy", r, 32'h0C);
    rd(2'd2, r); chk("R11 data write ignored while busy", r, 32'h77);
    end_txn(0);
  endtask

  task automatic t_end_rules();
    logic [7:0] r;
    t_write(1, 0, 1'b0, 1'b0, 1, 8'h01);
    wr(2'd3, 8'h20);
    chk("R9 clear without request ignored", cs_n, 32'h1);
    rd(2'd3, r); chk("R9 no pending flag", r, 32'h08);
    wr(2'd3, 8'h30);
    chk("R9 combined request keeps cs", cs_n, 32'h1);
    wr(2'd3, 8'h02);
    rd(2'd3, r); chk("R9 start ignored while pending", r, 32'h0A);
    wr(2'd3, 8'h20);
    chk("R9 release after pending", cs_n, 32'h3);
    wr(2'd3, 8'h10);
    rd(2'd3, r); chk("R9 request with no cs ignored", r, 32'h0);
  endtask

  task automatic t_enable();
    logic [7:0] r;
    t_write(1, 1, 1'b1, 1'b1, 2, 8'h02);
    wr(2'd1, 8'h04);
    chk("R6 disabled cs high", cs_n, 32'h3);
    chk("R6 disabled clock idle", sclk, 32'h1);
    chk("R6 disabled output low", mosi, 32'h0);
    rd(2'd3, r); chk("R6 R11 hold kept in status", r, 32'h08);
    wr(2'd3, 8'h02);
    rd(2'd3, r); chk("R6 start on disabled channel ignored", r, 32'h08);
    wr(2'd3, 8'h01);
    rd(2'd3, r); chk("R5 other channel start ignored", r, 32'h08);
    wr(2'd1, 8'h0C);
    chk("R6 re-enable drives cs", cs_n, 32'h1);
    end_txn(1);
    wr(2'd1, 8'h08);
    wr(2'd3, 8'h01);
    rd(2'd3, r); chk("R6 fresh start on disabled channel", r, 32'h0);
    chk("R6 cs stays high", cs_n, 32'h3);
    wr(2'd1, 8'h0C);
  endtask

  task automatic t_two_starts();
    logic [7:0] r;
    wr(2'd3, 8'h03);
    rd(2'd3, r); chk("R5 double start ignored", r, 32'h0);
    chk("R5 no cs on double start", cs_n, 32'h3);
    t_write(0, 0, 1'b0, 1'b1, 4, 8'h09);
    wr(2'd3, 8'h02);
    rd(2'd3, r); chk("R5 start on second channel ignored", r, 32'h04);
    chk("R5 first channel still selected", cs_n, 32'h2);
    end_txn(0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(0, 0, 1'b0, 1'b0, 0, 8'hA5);
    t_write(0, 0, 1'b0, 1'b0, 0, 8'h3C);
    end_txn(0);
    t_write(1, 2, 1'b1, 1'b1, 5, 8'h16);
    end_txn(1);
    t_write(0, 7, 1'b1, 1'b0, 1, 8'h01);
    end_txn(0);
    t_read(0, 1, 1'b0, 1'b1, 0, 8'hF0, 8'h9B, 1'b0);
    end_txn(0);
    t_read(1, 0, 1'b1, 1'b0, 3, 8'h5A, 8'h05, 1'b1);
    end_txn(1);
    t_read(0, 3, 1'b0, 1'b0, 0, 8'h81, 8'h6E, 1'b1);
    end_txn(0);
    t_busy_ignore();
    t_end_rules();
    t_enable();
    t_two_starts();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule